// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block pairs a free-running 16-bit up-counter with a 16-bit compare register and keeps checking the two for equality. When they agree, a 4-bit mode code decides the consequence: the output latch toggles, is set or is cleared, only the interrupt flag is raised, or a special event trigger is issued. The special event trigger pulses a strobe, optionally pulses a conversion-start strobe, and brings the counter back to zero on its next advance. This lets the compare register set the counter's period.

The counter advances only on cycles where the single-cycle `tick` enable is high. A match is acted on once for each counter value. A compare write re-arms the comparison against the value the counter holds at that moment. The interrupt flag stays set until software pulses `flag_clr`. All outputs are registered. Any effect of a match shows on the ports one clock after the cycle in which the match is present.

Top module: `cmp_match_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pin_out`, `pin_oe`, `irq_flag`, `trig_out`, `conv_start` and `tmr_ovf` are 0, and `tmr_val` is 0.
- R2: `tmr_val` increases by one at each clock edge where `tick` is high and holds otherwise. A step from all ones to zero gives a one-cycle `tmr_ovf` pulse.
- R3: A match is present when the compare register equals `tmr_val` and the comparison is armed. Arming happens on a tick or on a compare write. A match disarms the comparison, so a stalled counter acts only once. A compare write of the current counter value causes a fresh match.
- R4: Mode code 4'b0010 toggles the output latch on each match and drives `pin_oe` high.
- R5: Mode code 4'b1000 sets the latch on a match and mode code 4'b1001 clears it. Both drive `pin_oe` high.
- R6: Mode code 4'b0000 and every code not named in R4, R5, R8 or R9 forces the latch low and `pin_oe` low. A match in these codes does not set `irq_flag`. Writing 4'b0000 brings a high `pin_out` low.
- R7: A match in codes 4'b0010, 4'b1000, 4'b1001, 4'b1010 or 4'b1011 sets `irq_flag`. The flag stays set until a `flag_clr` pulse. A `flag_clr` in the same cycle as such a match leaves the flag set.
- R8: Mode code 4'b1010 keeps `pin_oe` and `pin_out` low while matches still set `irq_flag`.
- R9: Mode code 4'b1011 gives a one-cycle `trig_out` pulse one clock after the match cycle and keeps `pin_oe` low. `conv_start` pulses together with `trig_out` only when `adc_en` is high.
- R10: After a trigger in mode 4'b1011, the next tick loads `tmr_val` with zero instead of advancing it, and `tmr_ovf` stays low.
- R11: A compare write made after the trigger and no later than the tick that would reset the counter cancels that reset, so the counter advances normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable, one cycle per step |
| mode_wr | input | 1 | Loads `mode_d` into the mode register |
| mode_d | input | 4 | Mode code to load |
| cmp_wr | input | 1 | Loads `cmp_d` into the compare register |
| cmp_d | input | 16 | Compare value to load |
| adc_en | input | 1 | Allows `conv_start` to follow the trigger |
| flag_clr | input | 1 | Software clear pulse for `irq_flag` |
| pin_out | output | 1 | Compare output latch |
| pin_oe | output | 1 | High when the mode drives the pin |
| irq_flag | output | 1 | Sticky match interrupt flag |
| trig_out | output | 1 | Special event trigger strobe |
| conv_start | output | 1 | Conversion-start strobe |
| tmr_val | output | 16 | Current counter value |
| tmr_ovf | output | 1 | Counter wrap pulse |

## Verification
A vector table runs each mode code against a compare value reached inside the tick count, one beyond it, and zero (matched through the compare write alone). This separates latch actions, drive enables and flag behaviour, and shows that unlisted codes behave as off. Directed sequences stall the counter on a matching value, re-write the compare value in place, and collide a flag clear with a match. They also run the trigger mode with the converter enabled and disabled, cancel a pending counter reset with a compare write, and wrap the counter all the way round to tell a genuine overflow apart from a trigger reset.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF    = 4'b0000,
    MD_TOGGLE = 4'b0010,
    MD_SET    = 4'b1000,
    MD_CLR    = 4'b1001,
    MD_SWI    = 4'b1010,
    MD_TRIG   = 4'b1011
  } cmu_mode_e;

  function automatic logic drives_pin(input logic [MODE_W-1:0] m);
    return (m == MD_TOGGLE) || (m == MD_SET) || (m == MD_CLR);
  endfunction

  function automatic logic raises_flag(input logic [MODE_W-1:0] m);
    return drives_pin(m) || (m == MD_SWI) || (m == MD_TRIG);
  endfunction
endpackage

// File: rtl/cmu_timer.sv
module cmu_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             trig_match_i,
  input  logic             cmp_wr_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             ovf_o
);
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W:0]   sum;
  logic             pend_q;
  logic             ovf_q;

  assign sum = {1'b0, tmr_q} + {{TMR_W{1'b0}}, 1'b1};

  // deferred reset request from a special event trigger
  always_ff @(posedge clk) begin
    if (rst)               pend_q <= 1'b0;
    else if (cmp_wr_i)     pend_q <= 1'b0;
    else if (trig_match_i) pend_q <= 1'b1;
    else if (tick_i)       pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (tick_i) begin
        if (pend_q && !cmp_wr_i) begin
          tmr_q <= '0;
        end else begin
          tmr_q <= sum[TMR_W-1:0];
          ovf_q <= sum[TMR_W];
        end
      end
    end
  end

  assign tmr_o = tmr_q;
  assign ovf_o = ovf_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(tmr_q));

  assert_no_ovf_on_trig_R10: assert property (@(posedge clk) disable iff (rst)
    (tick_i && pend_q && !cmp_wr_i) |=> (tmr_q == '0 && !ovf_q));
endmodule

// File: rtl/cmu_detect.sv
module cmu_detect #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             cmp_wr_i,
  input  logic [TMR_W-1:0] cmp_d_i,
  input  logic [TMR_W-1:0] tmr_i,
  output logic             match_o
);
  logic [TMR_W-1:0] cmp_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst)           cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= cmp_d_i;
  end

  // one action per counter value: disarm on match, re-arm on new value
  always_ff @(posedge clk) begin
    if (rst)                     armed_q <= 1'b0;
    else if (tick_i || cmp_wr_i) armed_q <= 1'b1;
    else if (match_o)            armed_q <= 1'b0;
  end

  assign match_o = armed_q && (tmr_i == cmp_q);

  assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (match_o && !tick_i && !cmp_wr_i) |=> !match_o);
endmodule

// File: rtl/cmu_action.sv
module cmu_action
  import cmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_d_i,
  input  logic              match_i,
  input  logic              adc_en_i,
  input  logic              flag_clr_i,
  output logic              trig_match_o,
  output logic              pin_o,
  output logic              oe_o,
  output logic              flag_o,
  output logic              trig_o,
  output logic              conv_o
);
  logic [MODE_W-1:0] mode_q;
  logic latch_q, oe_q, flag_q, trig_q, conv_q;

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= MD_OFF;
    else if (mode_wr_i) mode_q <= mode_d_i;
  end

  assign trig_match_o = match_i && (mode_q == MD_TRIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      oe_q    <= 1'b0;
      flag_q  <= 1'b0;
      trig_q  <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      oe_q   <= drives_pin(mode_q);
      trig_q <= trig_match_o;
      conv_q <= trig_match_o && adc_en_i;
      if (!drives_pin(mode_q)) begin
        latch_q <= 1'b0;
      end else if (match_i) begin
        case (mode_q)
          MD_TOGGLE: latch_q <= ~latch_q;
          MD_SET:    latch_q <= 1'b1;
          default:   latch_q <= 1'b0;
        endcase
      end
      if (match_i && raises_flag(mode_q)) flag_q <= 1'b1;
      else if (flag_clr_i)                flag_q <= 1'b0;
    end
  end

  assign pin_o  = latch_q;
  assign oe_o   = oe_q;
  assign flag_o = flag_q;
  assign trig_o = trig_q;
  assign conv_o = conv_q;

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    (match_i && raises_flag(mode_q)) |=> flag_q);

  assert_off_low_R6: assert property (@(posedge clk) disable iff (rst)
    !drives_pin(mode_q) |=> (!latch_q && !oe_q));

  assert_conv_with_trig_R9: assert property (@(posedge clk) disable iff (rst)
    conv_q |-> trig_q);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmu_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mode_wr,
  input  logic [3:0]       mode_d,
  input  logic             cmp_wr,
  input  logic [TMR_W-1:0] cmp_d,
  input  logic             adc_en,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq_flag,
  output logic             trig_out,
  output logic             conv_start,
  output logic [TMR_W-1:0] tmr_val,
  output logic             tmr_ovf
);
  logic [TMR_W-1:0] tmr;
  logic             match;
  logic             trig_match;

  cmu_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .trig_match_i(trig_match),
    .cmp_wr_i(cmp_wr), .tmr_o(tmr), .ovf_o(tmr_ovf)
  );

  cmu_detect #(.TMR_W(TMR_W)) u_detect (
    .clk(clk), .rst(rst), .tick_i(tick), .cmp_wr_i(cmp_wr),
    .cmp_d_i(cmp_d), .tmr_i(tmr), .match_o(match)
  );

  cmu_action u_action (
    .clk(clk), .rst(rst), .mode_wr_i(mode_wr), .mode_d_i(mode_d),
    .match_i(match), .adc_en_i(adc_en), .flag_clr_i(flag_clr),
    .trig_match_o(trig_match), .pin_o(pin_out), .oe_o(pin_oe),
    .flag_o(irq_flag), .trig_o(trig_out), .conv_o(conv_start)
  );

  assign tmr_val = tmr;
endmodule

// File: tb/cmp_match_unit_bench.sv
module cmp_match_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, mode_wr = 1'b0, cmp_wr = 1'b0, adc_en = 1'b0, flag_clr = 1'b0;
  logic [3:0]  mode_d = 4'd0;
  logic [15:0] cmp_d = 16'd0;
  logic pin_out, pin_oe, irq_flag, trig_out, conv_start, tmr_ovf;
  logic [15:0] tmr_val;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_match_unit u_cmp_match_unit (
    .clk(clk), .rst(rst), .tick(tick), .mode_wr(mode_wr), .mode_d(mode_d),
    .cmp_wr(cmp_wr), .cmp_d(cmp_d), .adc_en(adc_en), .flag_clr(flag_clr),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag), .trig_out(trig_out),
    .conv_start(conv_start), .tmr_val(tmr_val), .tmr_ovf(tmr_ovf)
  );

  // {mode, cmp, ticks, pin, oe, flag}
  localparam logic [30:0] VECS [0:7] = '{
    {4'b0010, 16'd5, 8'd8, 3'b111},
    {4'b0010, 16'd9, 8'd8, 3'b010},
    {4'b1000, 16'd3, 8'd3, 3'b111},
    {4'b1001, 16'd3, 8'd5, 3'b011},
    {4'b1010, 16'd2, 8'd4, 3'b001},
    {4'b0000, 16'd2, 8'd4, 3'b000},
    {4'b0111, 16'd2, 8'd4, 3'b000},
    {4'b1000, 16'd0, 8'd2, 3'b111}
  };

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick = 0; mode_wr = 0; cmp_wr = 0; flag_clr = 0;
    rst = 1; cyc(); cyc(); rst = 0; cyc();
  endtask

  task automatic wr_mode(input logic [3:0] m);
    mode_d = m; mode_wr = 1; cyc(); mode_wr = 0;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    cmp_d = v; cmp_wr = 1; cyc(); cmp_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1;
    do_reset();
    // R1 reset state
    chk("R1 pin", pin_out, 0); chk("R1 oe", pin_oe, 0); chk("R1 flag", irq_flag, 0);
    chk("R1 trig", trig_out, 0); chk("R1 conv", conv_start, 0);
    chk("R1 tmr", tmr_val, 0); chk("R1 ovf", tmr_ovf, 0);

    // table: R4 R5 R6 R8 R3
    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr_mode(VECS[i][30:27]);
      wr_cmp(VECS[i][26:11]);
      tick = 1;
      for (int k = 0; k < int'(VECS[i][10:3]); k++) cyc();
      tick = 0;
      cyc(); cyc(); cyc();
      chk("R4/R5/R6/R8 pin", pin_out, VECS[i][2]);
      chk("R4/R5/R6/R8 oe", pin_oe, VECS[i][1]);
      chk("R7 flag", irq_flag, VECS[i][0]);
      chk("R2 tmr", tmr_val, VECS[i][10:3]);
    end

    // R3 stall and re-arm by compare write, R7 clear, R6 zero write
    do_reset();
    wr_mode(4'b0010); wr_cmp(16'd5);
    tick = 1; repeat (5) cyc(); tick = 0;
    cyc();
    chk("R4 toggle", pin_out, 1);
    repeat (10) cyc();
    chk("R3 stalled no retoggle", pin_out, 1);
    wr_cmp(16'd5); cyc(); cyc();
    chk("R3 rearm toggles back", pin_out, 0);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R7 cleared", irq_flag, 0);
    wr_cmp(16'd5);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R7 clear vs match", irq_flag, 1);
    chk("R4 toggle again", pin_out, 1);
    wr_mode(4'b0000); cyc(); cyc();
    chk("R6 zero write pin", pin_out, 0);
    chk("R6 zero write oe", pin_oe, 0);

    // R9 R10 trigger with converter enabled
    do_reset(); adc_en = 1;
    wr_mode(4'b1011); wr_cmp(16'd4);
    tick = 1; repeat (4) cyc();
    chk("R9 no early trig", trig_out, 0);
    cyc();
    chk("R9 trig", trig_out, 1); chk("R9 conv", conv_start, 1);
    chk("R10 tmr advances on trig edge", tmr_val, 5); chk("R9 oe", pin_oe, 0);
    cyc();
    chk("R9 trig one cycle", trig_out, 0);
    chk("R10 tmr reset", tmr_val, 0); chk("R10 no ovf", tmr_ovf, 0);
    chk("R7 flag trig", irq_flag, 1); chk("R9 pin", pin_out, 0);
    tick = 0;

    // R9 converter disabled
    do_reset(); adc_en = 0;
    wr_mode(4'b1011); wr_cmp(16'd4);
    tick = 1; repeat (5) cyc(); tick = 0;
    chk("R9 trig adc off", trig_out, 1); chk("R9 conv gated", conv_start, 0);

    // R11 cancel
    do_reset();
    wr_mode(4'b1011); wr_cmp(16'd4);
    tick = 1; repeat (5) cyc();
    chk("R11 trig", trig_out, 1);
    cmp_d = 16'd100; cmp_wr = 1; cyc(); cmp_wr = 0;
    chk("R11 reset cancelled", tmr_val, 6);
    cyc();
    chk("R11 keeps counting", tmr_val, 7);
    tick = 0;

    // R2 wrap
    do_reset();
    tick = 1; repeat (65535) cyc();
    chk("R2 top", tmr_val, 16'hFFFF); chk("R2 no ovf yet", tmr_ovf, 0);
    cyc();
    chk("R2 wrap", tmr_val, 0); chk("R2 ovf", tmr_ovf, 1);
    tick = 0; cyc();
    chk("R2 ovf pulse", tmr_ovf, 0); chk("R2 hold", tmr_val, 0);

    finish_run();
  end
endmodule